// File: doc/BRIEF.md
# Threshold-Signalling Byte FIFO

This block is a single byte queue that sits between a serial bus engine and a host register port. One control bit sets the direction. In read direction the engine pushes bytes that arrive from the bus, and the host pops them. In write direction the host pushes bytes that are waiting to go out, and the engine pops them. The host sees the current fill level as a count. A request line tells software when it should act: in read direction when enough bytes have gathered, and in write direction when the queue has drained to a low watermark.

Each direction has its own threshold. A single mode bit selects how the level is compared against it. In the strict mode the request needs the level to be past the threshold. In the inclusive mode the request also fires when the level equals the threshold. A flush control empties the queue. Its status reads back as busy for one cycle and then clears by itself. Host accesses that go against the direction, that read an empty queue, or that write a full queue each produce a one-cycle error pulse, and a separate status block latches these pulses.

Top module: `thresh_byte_fifo`

## Requirements
- R1: While and right after reset, `fillLevel` is 0, `flushBusy` is 0, and all three error pulses are 0.
- R2: With `dirRead`=1, bytes pushed by the engine come out to the host in arrival order. `hostRdData` shows the oldest byte before `hostRdEn` removes it.
- R3: With `dirRead`=0, bytes written by the host come out on `engPopData` in arrival order, and `engPop` removes them.
- R4: With `dirRead`=1, `request` is 1 exactly when `fillLevel` > `rxThresh`, or when `fillLevel` >= `rxThresh` while `inclusive`=1.
- R5: With `dirRead`=0, `request` is 1 exactly when `fillLevel` < `txThresh`, or when `fillLevel` <= `txThresh` while `inclusive`=1. A setting of 1 in strict mode, or 0 in inclusive mode, flags an empty queue.
- R6: A cycle with `flushWr`=1 makes `flushBusy` read 1 after that edge. At the following edge `fillLevel` goes to 0 and `flushBusy` returns to 0.
- R7: A host read with `dirRead`=1 while `fillLevel` is 0 raises `errUnderflow` for the single cycle after the access and leaves the level at 0.
- R8: A host write with `dirRead`=0 while `fillLevel` equals the depth raises `errOverflow` for the single cycle after the access. The byte is dropped, and the stored contents stay as they were.
- R9: A host write with `dirRead`=1, or a host read with `dirRead`=0, raises `errIllegal` for the single cycle after the access and leaves the fill level unchanged.
- R10: `fillLevel` counts the stored bytes from 0 up to the depth. A push and a pop in the same cycle leave it unchanged.
- R11: An engine push with `dirRead`=0, or an engine pop with `dirRead`=1, has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirRead | input | 1 | 1: engine fills and host drains; 0: host fills and engine drains |
| inclusive | input | 1 | 1: a level equal to the threshold also raises the request |
| rxThresh | input | 4 | Read-direction threshold |
| txThresh | input | 4 | Write-direction threshold |
| flushWr | input | 1 | Host writes 1 to the flush control |
| flushBusy | output | 1 | Flush control read-back, 1 while a flush is pending |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdEn | input | 1 | Host read strobe (pops the shown byte) |
| hostRdData | output | 8 | Oldest stored byte, as seen by the host |
| engPush | input | 1 | Engine push strobe |
| engPushData | input | 8 | Engine push byte |
| engPop | input | 1 | Engine pop strobe |
| engPopData | output | 8 | Oldest stored byte, as seen by the engine |
| fillLevel | output | 5 | Number of stored bytes |
| request | output | 1 | Threshold request level |
| errUnderflow | output | 1 | Pulse: host read of an empty queue |
| errOverflow | output | 1 | Pulse: host write into a full queue |
| errIllegal | output | 1 | Pulse: host access against the direction |

## Verification
The bench builds the block with its default depth of 16, so the 4-bit thresholds cover every value from 0 to 15. With that setting, a strict read threshold of 15 can only raise the request once the queue is completely full. This lets the table reach both ends of the comparison: threshold 0 against an empty queue, and threshold 15 against a full one. The same depth keeps an overflow-and-drain pass short enough to check every stored byte, which confirms that the rejected write never reached storage.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  typedef struct packed {
    logic push;     // store one byte at the tail
    logic pop;      // drop the byte at the head
    logic hostSrc;  // push byte comes from the host port
    logic flush;    // return pointers and count to zero
  } fifoCmd_t;
endpackage

// File: rtl/tbf_ctrl.sv
module tbf_ctrl #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dirRead,
  input  logic                 inclusive,
  input  logic [THR_W-1:0]     rxThresh,
  input  logic [THR_W-1:0]     txThresh,
  input  logic                 flushWr,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic                 engPush,
  input  logic                 engPop,
  input  logic [CNT_W-1:0]     count,
  output tbf_pkg::fifoCmd_t    cmd,
  output logic                 request,
  output logic                 flushBusy,
  output logic                 errUnderflow,
  output logic                 errOverflow,
  output logic                 errIllegal
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic isEmpty, isFull;
  logic pushReq, popReq;
  logic flushPend;
  logic uflNext, oflNext, illNext;
  logic [CNT_W-1:0] rxLvl, txLvl;

  assign isEmpty = (count == '0);
  assign isFull  = (count == FULL_LVL);
  assign rxLvl   = CNT_W'(rxThresh);
  assign txLvl   = CNT_W'(txThresh);

  always_comb begin
    cmd = '0;
    if (dirRead) begin
      pushReq     = engPush;
      popReq      = hostRdEn;
      cmd.hostSrc = 1'b0;
    end else begin
      pushReq     = hostWrEn;
      popReq      = engPop;
      cmd.hostSrc = 1'b1;
    end
    cmd.flush = flushPend;
    cmd.push  = pushReq && !isFull && !flushPend;
    cmd.pop   = popReq && !isEmpty && !flushPend;
  end

  always_comb begin
    if (dirRead) request = inclusive ? (count >= rxLvl) : (count > rxLvl);
    else         request = inclusive ? (count <= txLvl) : (count < txLvl);
  end

  assign uflNext = hostRdEn && dirRead && isEmpty;
  assign oflNext = hostWrEn && !dirRead && isFull;
  assign illNext = (hostRdEn && !dirRead) || (hostWrEn && dirRead);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushPend    <= 1'b0;
      errUnderflow <= 1'b0;
      errOverflow  <= 1'b0;
      errIllegal   <= 1'b0;
    end else begin
      flushPend    <= flushWr;
      errUnderflow <= uflNext;
      errOverflow  <= oflNext;
      errIllegal   <= illNext;
    end
  end

  assign flushBusy = flushPend;
endmodule

// File: rtl/tbf_datapath.sv
module tbf_datapath #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  tbf_pkg::fifoCmd_t  cmd,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic [DATA_W-1:0]  engPushData,
  output logic [DATA_W-1:0]  headData,
  output logic [CNT_W-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] pushByte;

  assign pushByte = cmd.hostSrc ? hostWrData : engPushData;
  assign headData = store[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (cmd.push) store[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= nextPtr(wrPtr);
      if (cmd.pop)  rdPtr <= nextPtr(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/thresh_byte_fifo.sv
module thresh_byte_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRead,
  input  logic              inclusive,
  input  logic [THR_W-1:0]  rxThresh,
  input  logic [THR_W-1:0]  txThresh,
  input  logic              flushWr,
  output logic              flushBusy,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              engPush,
  input  logic [DATA_W-1:0] engPushData,
  input  logic              engPop,
  output logic [DATA_W-1:0] engPopData,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              request,
  output logic              errUnderflow,
  output logic              errOverflow,
  output logic              errIllegal
);
  tbf_pkg::fifoCmd_t cmd;
  logic [DATA_W-1:0] headData;

  tbf_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirRead(dirRead), .inclusive(inclusive),
    .rxThresh(rxThresh), .txThresh(txThresh), .flushWr(flushWr),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .engPush(engPush), .engPop(engPop),
    .count(fillLevel), .cmd(cmd), .request(request), .flushBusy(flushBusy),
    .errUnderflow(errUnderflow), .errOverflow(errOverflow), .errIllegal(errIllegal)
  );

  tbf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostWrData(hostWrData),
    .engPushData(engPushData), .headData(headData), .count(fillLevel)
  );

  assign hostRdData = headData;
  assign engPopData = headData;
endmodule

// File: rtl/tbf_checker.sv
module tbf_checker #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             dirRead,
  input logic             inclusive,
  input logic [THR_W-1:0] txThresh,
  input logic             flushBusy,
  input logic             hostWrEn,
  input logic             hostRdEn,
  input logic [CNT_W-1:0] fillLevel,
  input logic             request,
  input logic             errUnderflow,
  input logic             errOverflow,
  input logic             errIllegal
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (fillLevel == '0 && !flushBusy && !errUnderflow && !errOverflow && !errIllegal));

  p_rx_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dirRead && !inclusive && fillLevel == '0) |-> !request);

  p_tx_empty_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!dirRead && fillLevel == '0 && (inclusive || txThresh != '0)) |-> request);

  p_flush_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |=> (fillLevel == '0));

  p_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && dirRead && fillLevel == '0) |=> errUnderflow);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !dirRead && fillLevel == FULL_LVL) |=> errOverflow);

  p_illegal_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((hostRdEn && !dirRead) || (hostWrEn && dirRead)) |=> errIllegal);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FULL_LVL);
endmodule

bind thresh_byte_fifo tbf_checker #(.DEPTH(DEPTH), .THR_W(THR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .dirRead(dirRead), .inclusive(inclusive), .txThresh(txThresh),
  .flushBusy(flushBusy), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .fillLevel(fillLevel),
  .request(request), .errUnderflow(errUnderflow), .errOverflow(errOverflow),
  .errIllegal(errIllegal)
);

// File: tb/thresh_byte_fifo_test.sv
module thresh_byte_fifo_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN;
  logic       dirRead, inclusive;
  logic [3:0] rxThresh, txThresh;
  logic       flushWr, flushBusy;
  logic       hostWrEn, hostRdEn, engPush, engPop;
  logic [7:0] hostWrData, hostRdData, engPushData, engPopData;
  logic [4:0] fillLevel;
  logic       request, errUnderflow, errOverflow, errIllegal;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  thresh_byte_fifo #(.DEPTH(DEPTH), .DATA_W(8)) uut (
    .clk(clk), .rstN(rstN), .dirRead(dirRead), .inclusive(inclusive),
    .rxThresh(rxThresh), .txThresh(txThresh), .flushWr(flushWr), .flushBusy(flushBusy),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .hostRdData(hostRdData), .engPush(engPush), .engPushData(engPushData),
    .engPop(engPop), .engPopData(engPopData), .fillLevel(fillLevel), .request(request),
    .errUnderflow(errUnderflow), .errOverflow(errOverflow), .errIllegal(errIllegal)
  );

  // {dirRead, inclusive, threshold[3:0], fill[4:0], expected request}
  localparam logic [11:0] VEC [14] = '{
    {1'b1, 1'b0, 4'd3,  5'd3,  1'b0},
    {1'b1, 1'b0, 4'd3,  5'd4,  1'b1},
    {1'b1, 1'b1, 4'd3,  5'd3,  1'b1},
    {1'b1, 1'b1, 4'd3,  5'd2,  1'b0},
    {1'b1, 1'b0, 4'd15, 5'd15, 1'b0},
    {1'b1, 1'b0, 4'd15, 5'd16, 1'b1},
    {1'b1, 1'b1, 4'd0,  5'd0,  1'b1},
    {1'b0, 1'b0, 4'd1,  5'd0,  1'b1},
    {1'b0, 1'b0, 4'd1,  5'd1,  1'b0},
    {1'b0, 1'b1, 4'd0,  5'd0,  1'b1},
    {1'b0, 1'b1, 4'd0,  5'd1,  1'b0},
    {1'b0, 1'b0, 4'd4,  5'd3,  1'b1},
    {1'b0, 1'b1, 4'd4,  5'd4,  1'b1},
    {1'b0, 1'b1, 4'd4,  5'd5,  1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    hostWrEn = 1'b0; hostRdEn = 1'b0; engPush = 1'b0; engPop = 1'b0; flushWr = 1'b0;
  endtask

  task automatic doFlush();
    flushWr = 1'b1;
    tick();
    tick();
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; dirRead = 1'b1; inclusive = 1'b0; rxThresh = '0; txThresh = '0;
    flushWr = 1'b0; hostWrEn = 1'b0; hostRdEn = 1'b0; engPush = 1'b0; engPop = 1'b0;
    hostWrData = '0; engPushData = '0;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;

    // R1 reset state
    chk("R1 level", fillLevel, 0);
    chk("R1 flushBusy", flushBusy, 0);
    chk("R1 errors", {errUnderflow, errOverflow, errIllegal}, 0);

    // R4 R5 R10 threshold table
    foreach (VEC[i]) begin
      automatic logic       vd   = VEC[i][11];
      automatic logic       vi   = VEC[i][10];
      automatic logic [3:0] vthr = VEC[i][9:6];
      automatic int         vf   = int'(VEC[i][5:1]);
      dirRead = vd; inclusive = vi;
      rxThresh = vd ? vthr : ~vthr;
      txThresh = vd ? ~vthr : vthr;
      doFlush();
      for (int k = 0; k < vf; k++) begin
        if (vd) begin engPush = 1'b1; engPushData = 8'(k); end
        else begin hostWrEn = 1'b1; hostWrData = 8'(k); end
        tick();
      end
      chk("R10 table level", fillLevel, vf);
      chk(vd ? "R4 read request" : "R5 write request", request, VEC[i][0]);
    end

    // R2 read-direction order, R10 simultaneous push/pop
    dirRead = 1'b1; inclusive = 1'b0; rxThresh = 4'd15;
    doFlush();
    engPush = 1'b1; engPushData = 8'h11; tick();
    engPush = 1'b1; engPushData = 8'h22; tick();
    chk("R2 head byte", hostRdData, 8'h11);
    engPush = 1'b1; engPushData = 8'h33; hostRdEn = 1'b1; tick();
    chk("R10 push+pop level", fillLevel, 2);
    chk("R2 second byte", hostRdData, 8'h22);
    hostRdEn = 1'b1; tick();
    chk("R2 third byte", hostRdData, 8'h33);

    // R11 engine pop in read direction ignored
    engPop = 1'b1; tick();
    chk("R11 eng pop ignored level", fillLevel, 1);
    chk("R11 eng pop ignored data", hostRdData, 8'h33);

    // R6 flush timing
    flushWr = 1'b1; tick();
    chk("R6 busy set", flushBusy, 1);
    chk("R6 level held", fillLevel, 1);
    tick();
    chk("R6 busy clear", flushBusy, 0);
    chk("R6 level zero", fillLevel, 0);

    // R7 underflow
    hostRdEn = 1'b1; tick();
    chk("R7 underflow pulse", errUnderflow, 1);
    chk("R7 level", fillLevel, 0);
    tick();
    chk("R7 pulse ends", errUnderflow, 0);

    // R9 illegal host write in read direction
    engPush = 1'b1; engPushData = 8'h77; tick();
    hostWrEn = 1'b1; hostWrData = 8'h99; tick();
    chk("R9 illegal write pulse", errIllegal, 1);
    chk("R9 level after write", fillLevel, 1);
    chk("R9 data kept", hostRdData, 8'h77);
    tick();
    chk("R9 pulse ends", errIllegal, 0);

    // R3 write-direction order, R9 illegal read, R11 engine push ignored
    dirRead = 1'b0; txThresh = 4'd0;
    doFlush();
    for (int k = 0; k < 5; k++) begin
      hostWrEn = 1'b1; hostWrData = 8'h60 + 8'(k); tick();
    end
    hostRdEn = 1'b1; tick();
    chk("R9 illegal read pulse", errIllegal, 1);
    chk("R9 level after read", fillLevel, 5);
    engPush = 1'b1; engPushData = 8'hCC; tick();
    chk("R11 eng push ignored", fillLevel, 5);
    for (int k = 0; k < 5; k++) begin
      chk("R3 engine byte", engPopData, 8'h60 + k);
      engPop = 1'b1; tick();
    end
    chk("R3 drained", fillLevel, 0);

    // R8 overflow
    doFlush();
    for (int k = 0; k < DEPTH; k++) begin
      hostWrEn = 1'b1; hostWrData = 8'h40 + 8'(k); tick();
    end
    chk("R8 full level", fillLevel, DEPTH);
    hostWrEn = 1'b1; hostWrData = 8'hEE; tick();
    chk("R8 overflow pulse", errOverflow, 1);
    chk("R8 level held", fillLevel, DEPTH);
    tick();
    chk("R8 pulse ends", errOverflow, 0);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R8 contents kept", engPopData, 8'h40 + k);
      engPop = 1'b1; tick();
    end
    chk("R8 drained", fillLevel, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule